// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer

This block is a register-mapped timer with a parameterised number of independent channels. Each channel holds a 64-bit reload interval and a 64-bit counter. It also has a control byte that starts and stops counting, requests a reload, picks a power-of-two prescaler and chooses between periodic and one-shot behaviour. All channels share one interrupt enable register and one interrupt status register, with bit n of each belonging to channel n. The single interrupt output is high while any channel has both its status bit and its enable bit set.

Software writes and reads the registers through a single-cycle port. A write is taken on the clock edge where the write strobe is high. Read data is combinational from the address. A channel counts down once per prescaled tick. When it steps from 1 to 0 it flags its status bit. In periodic mode it then refills from the interval. In one-shot mode it parks at zero and drops its own enable. An interval of all ones in the low word turns a channel into a free-running time base, and the complement of its low count rises by one per tick.

When software stops a channel, the stop is not immediate. The counter keeps running for two more clock cycles, so software must allow for that latency.

Top module: `cdtimer`

## Requirements
- R1: After reset every register reads 0 and `irq` is 0.
- R2: Byte offsets are as follows. Interrupt enable is at 0x00 and interrupt status is at 0x04. For channel n, control is at 0x20·n+0x10, interval low at +0x14, interval high at +0x18, count low at +0x1C and count high at +0x20. Any other offset reads 0. Writes to the count words have no effect.
- R3: Control bit 0 is the run enable, bit 1 is reload, bits 6:4 are the prescaler select and bit 7 is one-shot. A write with bit 1 set copies the 64-bit interval into the counter on the next clock edge, whether or not the channel runs. Bit 1 then reads 0.
- R4: With prescaler select p, a running channel decrements once every 2^p clock cycles. The first decrement comes 2^p cycles after the reload.
- R5: In periodic mode a step from 1 to 0 sets the channel's status bit and loads the interval instead of 0. The count therefore cycles N, N-1, …, 1.
- R6: In one-shot mode a step from 1 to 0 sets the status bit, leaves the count at 0 and clears control bit 0.
- R7: When a write clears control bit 0 of a running channel, the counter still advances on the write edge and on the two following edges, and then holds.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R9: `irq` is the OR over all channels of (status bit AND enable bit).
- R10: With the interval high word at 0 and the low word at 0xFFFFFFFF in periodic mode, the low count falls by one per tick, so its bitwise complement rises by one per tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer and register clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, taken on the rising edge |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps all eight prescaler selects in one-shot mode and counts the exact cycles from the control write to the status flag. A prescaler that was off by one, or a reload that consumed a tick, would shift that count. It follows a periodic channel cycle by cycle, which catches a counter that shows 0 between periods or refills one tick late. It times the stop window after a disable write, which catches a design that halts at once or runs on too long. It also checks that a one-shot channel parks at 0 with its enable cleared, that a reload-only write loads the counter without starting it, and that writes of 0 to status and writes to the count words change nothing.

// File: rtl/cdtimer_pkg.sv
package cdtimer_pkg;

    localparam int DW        = 32;
    localparam int CNT_W     = 2 * DW;
    localparam int PSEL_W    = 3;
    localparam int PDIV_W    = (1 << PSEL_W) - 1;
    localparam int STOP_LAT  = 2;
    localparam int STOP_W    = $clog2(STOP_LAT + 1);

    localparam int OFF_IE     = 'h00;
    localparam int OFF_ST     = 'h04;
    localparam int CH_BASE    = 'h10;
    localparam int CH_SHIFT   = 5;

    localparam logic [CH_SHIFT-1:0] SUB_CTRL   = 5'h00;
    localparam logic [CH_SHIFT-1:0] SUB_IVL_LO = 5'h04;
    localparam logic [CH_SHIFT-1:0] SUB_IVL_HI = 5'h08;
    localparam logic [CH_SHIFT-1:0] SUB_CNT_LO = 5'h0C;
    localparam logic [CH_SHIFT-1:0] SUB_CNT_HI = 5'h10;

    typedef struct packed {
        logic              oneshot;
        logic [PSEL_W-1:0] psel;
        logic [1:0]        rsvd;
        logic              reload;
        logic              run;
    } ctrl_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_IE,
        SEL_ST,
        SEL_CTRL,
        SEL_IVL_LO,
        SEL_IVL_HI,
        SEL_CNT_LO,
        SEL_CNT_HI
    } reg_sel_e;

    function automatic ctrl_t ctrl_from_word(input logic [DW-1:0] w);
        ctrl_t c;
        c      = ctrl_t'(w[7:0]);
        c.rsvd = '0;
        return c;
    endfunction

    function automatic logic tick_due(input logic [PDIV_W-1:0] pre,
                                      input logic [PSEL_W-1:0] psel);
        logic [PDIV_W-1:0] mask;
        mask = PDIV_W'((1 << psel) - 1);
        return ((pre | ~mask) == '1);
    endfunction

endpackage

// File: rtl/cdtimer_regdec.sv
module cdtimer_regdec
    import cdtimer_pkg::*;
#(
    parameter int NUM_CH   = 2,
    parameter int ADDR_W   = 8,
    parameter int CH_IDX_W = 1
) (
    input  logic [ADDR_W-1:0]   addr,
    output reg_sel_e            sel,
    output logic [CH_IDX_W-1:0] ch
);

    logic [ADDR_W-1:0] rel;
    logic [ADDR_W-1:0] idx;

    always_comb begin
        sel = SEL_NONE;
        ch  = '0;
        rel = addr - ADDR_W'(CH_BASE);
        idx = rel >> CH_SHIFT;
        if (addr[1:0] == 2'b00) begin
            if (addr == ADDR_W'(OFF_IE)) begin
                sel = SEL_IE;
            end else if (addr == ADDR_W'(OFF_ST)) begin
                sel = SEL_ST;
            end else if (addr >= ADDR_W'(CH_BASE) && idx < ADDR_W'(NUM_CH)) begin
                ch = idx[CH_IDX_W-1:0];
                case (rel[CH_SHIFT-1:0])
                    SUB_CTRL:   sel = SEL_CTRL;
                    SUB_IVL_LO: sel = SEL_IVL_LO;
                    SUB_IVL_HI: sel = SEL_IVL_HI;
                    SUB_CNT_LO: sel = SEL_CNT_LO;
                    SUB_CNT_HI: sel = SEL_CNT_HI;
                    default:    sel = SEL_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/cdtimer_channel.sv
module cdtimer_channel
    import cdtimer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_we,
    input  logic             ivl_lo_we,
    input  logic             ivl_hi_we,
    input  logic [DW-1:0]    wdata,
    output ctrl_t            ctrl_o,
    output logic [CNT_W-1:0] ivl_o,
    output logic [CNT_W-1:0] count_o,
    output logic             hit_o
);

    ctrl_t             cfg;
    logic [CNT_W-1:0]  ivl;
    logic [CNT_W-1:0]  cnt;
    logic [PDIV_W-1:0] pre_cnt;
    logic [STOP_W-1:0] stop_cnt;
    logic              live;
    logic              tick;

    assign live  = cfg.run || (stop_cnt != '0);
    assign tick  = live && !cfg.reload && tick_due(pre_cnt, cfg.psel);
    assign hit_o = tick && (cnt == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= '0;
            ivl      <= '0;
            cnt      <= '0;
            pre_cnt  <= '0;
            stop_cnt <= '0;
        end else begin
            if (ivl_lo_we) ivl[DW-1:0]     <= wdata;
            if (ivl_hi_we) ivl[CNT_W-1:DW] <= wdata;

            if (stop_cnt != '0) stop_cnt <= stop_cnt - 1'b1;

            if (cfg.reload) begin
                cnt        <= ivl;
                cfg.reload <= 1'b0;
                pre_cnt    <= '0;
            end else if (live) begin
                pre_cnt <= pre_cnt + 1'b1;
            end

            if (tick) begin
                if (cnt <= CNT_W'(1)) begin
                    if (cfg.oneshot) begin
                        cnt     <= '0;
                        cfg.run <= 1'b0;
                    end else begin
                        cnt <= ivl;
                    end
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end

            if (ctrl_we) begin
                if (cfg.run && !wdata[0]) stop_cnt <= STOP_W'(STOP_LAT);
                cfg     <= ctrl_from_word(wdata);
                pre_cnt <= '0;
            end
        end
    end

    assign ctrl_o  = cfg;
    assign ivl_o   = ivl;
    assign count_o = cnt;

    // R3
    reload_load_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.reload && !ctrl_we) |=> (cnt == $past(ivl)));

    // R5
    periodic_refill_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_o && !cfg.oneshot) |=> (cnt == $past(ivl)));

    // R6
    oneshot_park_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_o && cfg.oneshot && !ctrl_we) |=> (cnt == '0 && !cfg.run));

    // R7
    halted_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!live && !cfg.reload && !ctrl_we) |=> $stable(cnt));

endmodule

// File: rtl/cdtimer.sv
module cdtimer
    import cdtimer_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic              irq
);

    localparam int CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    reg_sel_e            sel;
    logic [CH_IDX_W-1:0] ch;
    logic [NUM_CH-1:0]   ie_q;
    logic [NUM_CH-1:0]   st_q;
    logic [NUM_CH-1:0]   hit;
    ctrl_t               ctrl_a [NUM_CH];
    logic [CNT_W-1:0]    ivl_a  [NUM_CH];
    logic [CNT_W-1:0]    cnt_a  [NUM_CH];
    logic                wr_st;

    cdtimer_regdec #(
        .NUM_CH  (NUM_CH),
        .ADDR_W  (ADDR_W),
        .CH_IDX_W(CH_IDX_W)
    ) u_dec (
        .addr(addr),
        .sel (sel),
        .ch  (ch)
    );

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            logic here;
            assign here = wr_en && (ch == CH_IDX_W'(i));

            cdtimer_channel u_chan (
                .clk      (clk),
                .rst      (rst),
                .ctrl_we  (here && sel == SEL_CTRL),
                .ivl_lo_we(here && sel == SEL_IVL_LO),
                .ivl_hi_we(here && sel == SEL_IVL_HI),
                .wdata    (wdata),
                .ctrl_o   (ctrl_a[i]),
                .ivl_o    (ivl_a[i]),
                .count_o  (cnt_a[i]),
                .hit_o    (hit[i])
            );

            // R8
            status_clear_chk: assert property (@(posedge clk) disable iff (rst)
                (wr_st && wdata[i] && !hit[i]) |=> !st_q[i]);

            // R5
            status_source_chk: assert property (@(posedge clk) disable iff (rst)
                $rose(st_q[i]) |-> $past(hit[i]));
        end
    endgenerate

    assign wr_st = wr_en && (sel == SEL_ST);

    always_ff @(posedge clk) begin
        if (rst) begin
            ie_q <= '0;
            st_q <= '0;
        end else begin
            if (wr_en && sel == SEL_IE) ie_q <= wdata[NUM_CH-1:0];
            st_q <= (st_q & ~(wr_st ? wdata[NUM_CH-1:0] : '0)) | hit;
        end
    end

    always_comb begin
        case (sel)
            SEL_IE:     rdata = DW'(ie_q);
            SEL_ST:     rdata = DW'(st_q);
            SEL_CTRL:   rdata = DW'(ctrl_a[ch]);
            SEL_IVL_LO: rdata = ivl_a[ch][DW-1:0];
            SEL_IVL_HI: rdata = ivl_a[ch][CNT_W-1:DW];
            SEL_CNT_LO: rdata = cnt_a[ch][DW-1:0];
            SEL_CNT_HI: rdata = cnt_a[ch][CNT_W-1:DW];
            default:    rdata = '0;
        endcase
    end

    assign irq = |(st_q & ie_q);

endmodule

// File: tb/cdtimer_test.sv
`timescale 1ns/100ps
module cdtimer_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    cdtimer uut (
        .clk  (clk),
        .rst  (rst),
        .wr_en(wr_en),
        .addr (addr),
        .wdata(wdata),
        .rdata(rdata),
        .irq  (irq)
    );

    function automatic logic [7:0] a_ctrl(input int n);  return 8'(32*n + 'h10); endfunction
    function automatic logic [7:0] a_ivlo(input int n);  return 8'(32*n + 'h14); endfunction
    function automatic logic [7:0] a_ivhi(input int n);  return 8'(32*n + 'h18); endfunction
    function automatic logic [7:0] a_cnlo(input int n);  return 8'(32*n + 'h1C); endfunction
    function automatic logic [7:0] a_cnhi(input int n);  return 8'(32*n + 'h20); endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] base;
        int c;

        rst = 1'b1; wr_en = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_chk("R1 ie", 8'h00, 0);
        rd_chk("R1 st", 8'h04, 0);
        rd_chk("R1 ctrl0", a_ctrl(0), 0);
        @(negedge clk);
        rd_chk("R1 ivl1hi", a_ivhi(1), 0);
        rd_chk("R1 cnt1hi", a_cnhi(1), 0);
        chk("R1 irq", 32'(irq), 0);
        @(negedge clk);

        // R2 map, unmapped and read-only count
        rd_chk("R2 unmapped 08", 8'h08, 0);
        rd_chk("R2 unmapped 24", 8'h24, 0);
        rd_chk("R2 unmapped 50", 8'h50, 0);
        wr(8'h00, 32'h3);
        rd_chk("R2 ie readback", 8'h00, 32'h3);
        wr(8'h00, 32'h0);
        wr(a_cnlo(0), 32'hABCD);
        @(negedge clk);
        rd_chk("R2 count write ignored", a_cnlo(0), 0);
        wr(a_ivlo(1), 32'h2);
        wr(a_ivhi(1), 32'h1);
        rd_chk("R2 ivl1lo", a_ivlo(1), 32'h2);
        rd_chk("R2 ivl1hi", a_ivhi(1), 32'h1);

        // R3 reload without run, field readback
        wr(a_ctrl(1), 32'h02);
        @(negedge clk);
        rd_chk("R3 reload lo", a_cnlo(1), 32'h2);
        rd_chk("R3 reload hi", a_cnhi(1), 32'h1);
        rd_chk("R3 reload bit cleared", a_ctrl(1), 32'h0);
        repeat (3) @(negedge clk);
        rd_chk("R3 no run no count", a_cnlo(1), 32'h2);
        wr(a_ctrl(1), 32'hF0);
        rd_chk("R3 ctrl fields", a_ctrl(1), 32'hF0);
        wr(a_ctrl(1), 32'h00);

        // R4 R6 prescaler sweep, one-shot of 3
        wr(a_ivlo(0), 32'h3);
        wr(a_ivhi(0), 32'h0);
        for (int p = 0; p < 8; p++) begin
            wr(8'h04, 32'h3);
            wr(a_ctrl(0), 32'h83 | (p << 4));
            c = 0;
            forever begin
                rd(8'h04, v);
                if (v[0] || c > 600) break;
                @(negedge clk);
                c++;
            end
            chk($sformatf("R4 cycles p=%0d", p), 32'(c), 32'(1 + (3 << p)));
            repeat (4) @(negedge clk);
            rd_chk("R6 parked at zero", a_cnlo(0), 0);
            rd_chk("R6 run cleared", a_ctrl(0), 32'h80 | (p << 4));
        end

        // R8 R9 status and irq
        @(negedge clk);
        wr(8'h04, 32'h0);
        rd_chk("R8 write 0 keeps", 8'h04, 32'h1);
        chk("R9 irq masked", 32'(irq), 0);
        wr(8'h00, 32'h1);
        chk("R9 irq raised", 32'(irq), 1);
        wr(8'h04, 32'h1);
        rd_chk("R8 write 1 clears", 8'h04, 32'h0);
        chk("R9 irq dropped", 32'(irq), 0);
        wr(8'h00, 32'h0);

        // R5 periodic of 4 on channel 1
        wr(a_ivlo(1), 32'h4);
        wr(a_ivhi(1), 32'h0);
        wr(a_ctrl(1), 32'h03);
        for (int m = 1; m <= 12; m++) begin
            @(negedge clk);
            rd_chk($sformatf("R5 count m=%0d", m), a_cnlo(1), 32'(4 - ((m - 1) % 4)));
            rd(8'h04, v);
            chk($sformatf("R5 status m=%0d", m), 32'(v[1]), 32'(m >= 5));
        end

        // R7 stop latency
        wr(a_ivlo(1), 32'd100);
        wr(a_ctrl(1), 32'h03);
        repeat (10) @(negedge clk);
        rd(a_cnlo(1), base);
        wr(a_ctrl(1), 32'h00);
        rd_chk("R7 write edge", a_cnlo(1), base - 1);
        repeat (2) @(negedge clk);
        rd_chk("R7 two more edges", a_cnlo(1), base - 3);
        repeat (5) @(negedge clk);
        rd_chk("R7 held", a_cnlo(1), base - 3);

        // R10 free-running time base
        wr(a_ivlo(0), 32'hFFFF_FFFF);
        wr(a_ivhi(0), 32'h0);
        wr(a_ctrl(0), 32'h03);
        for (int m = 1; m <= 6; m++) begin
            @(negedge clk);
            rd(a_cnlo(0), v);
            chk($sformatf("R10 rising m=%0d", m), ~v, 32'(m - 1));
        end
        rd_chk("R10 high word", a_cnhi(0), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule